// File: doc/BRIEF.md
# 128-bit Parallel Copy Execution Slice

This block is a purely combinational decode-and-execute slice for three wide register copy operations in a MIPS-like core that has 128-bit multimedia registers. Each cycle it takes a 32-bit instruction word and the two 128-bit source operands read for that instruction (the `rs` and `rt` register values). It decides whether the word is one of its copy operations. For an accepted operation it reports a valid decode, the destination index, a write enable, the 128-bit result and a 32-bit mirror of that result for the narrow register file.

The operations are:
- a halfword broadcast, which spreads one 16-bit value across each 64-bit half of the result;
- a lower-doubleword pack, which joins the low doublewords of both sources;
- an upper-doubleword pack, which joins their high doublewords.

Decoding is exact. The major opcode, the funct field and the sa field must all match. Other sa values under the same opcode and funct are unallocated. These raise a trap flag when strict mode is on, and are silently dropped when it is off.

Top module: `ppc_copy_unit`

## Requirements
- R1: Halfword broadcast (opcode bits[31:26]=6'h1C, funct bits[5:0]=6'h29, sa bits[10:6]=5'h1B) yields rt[15:0] in each of the four 16-bit lanes of result bits [63:0] and rt[79:64] in each of the four lanes of bits [127:64].
- R2: For the halfword broadcast, the 32-bit mirror output equals {rt[15:0], rt[15:0]}.
- R3: The halfword broadcast ignores both the rs field (bits[25:21]) and the rs operand value: any of them gives an identical result.
- R4: Lower-doubleword pack (opcode 6'h1C, funct 6'h09, sa 5'h0E) yields rs[63:0] in result bits [127:64] and rt[63:0] in bits [63:0].
- R5: Upper-doubleword pack (opcode 6'h1C, funct 6'h29, sa 5'h0E) yields rt[127:64] in result bits [127:64] and rs[127:64] in bits [63:0].
- R6: Word 32'h70081EE9 decodes as the halfword broadcast with valid set, destination index 3 (rd, bits[15:11]) and write enable set.
- R7: With strict mode on, an opcode 6'h1C word whose funct is 6'h29 or 6'h09 and whose sa matches none of the allocated values (for example 5'h1C or 5'h1A) raises the trap flag, with valid and write enable low.
- R8: With strict mode off, the same unallocated words give no trap, no valid, no write enable and a zero result.
- R9: An accepted operation with destination index 0 reports valid high and write enable low.
- R10: A word with a different major opcode, or with opcode 6'h1C and a funct other than 6'h29 or 6'h09, gives no valid, no write enable and no trap, even in strict mode.
- R11: For every accepted operation, the 32-bit mirror equals result bits [31:0], and the reported destination equals the rd field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_val_i | input | 128 | Operand read for the rs field |
| rt_val_i | input | 128 | Operand read for the rt field |
| strict_i | input | 1 | Trap unallocated group encodings when high |
| valid_o | output | 1 | Word is one of the three copy operations |
| rd_o | output | 5 | Destination register index (0 when not valid) |
| wr_en_o | output | 1 | Write enable for the wide and narrow files |
| wb128_o | output | 128 | Full-width result |
| wb32_o | output | 32 | Low mirror of the result for the narrow file |
| trap_o | output | 1 | Unallocated encoding seen in strict mode |

## Verification
Two of the block's functions can fall in the same cycle. One is an accepted decode, which may still have its write suppressed when the destination is index 0. The other is the strict trap. A correct design must never raise the trap together with either valid or write enable.

The bench provokes this boundary by sweeping the sa field one step either side of the allocated values, under the same opcode and funct, with strict mode both on and off. It judges the three flags together at each point. It also pairs a valid broadcast with destination 0, to show that write suppression leaves the decode intact.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  localparam int unsigned INSN_W    = 32;
  localparam int unsigned REG_IDX_W = 5;

  localparam logic [5:0] OPC_WIDE   = 6'h1C;
  localparam logic [5:0] FN_GRP_HI  = 6'h29;
  localparam logic [5:0] FN_GRP_LO  = 6'h09;
  localparam logic [4:0] SA_HBCAST  = 5'h1B;
  localparam logic [4:0] SA_UPACK   = 5'h0E;
  localparam logic [4:0] SA_LPACK   = 5'h0E;

  typedef enum logic [1:0] {
    CP_NONE  = 2'd0,
    CP_HBC   = 2'd1,
    CP_UPACK = 2'd2,
    CP_LPACK = 2'd3
  } copy_op_e;

  typedef struct packed {
    logic [5:0]           opc;
    logic [REG_IDX_W-1:0] rs;
    logic [REG_IDX_W-1:0] rt;
    logic [REG_IDX_W-1:0] rd;
    logic [4:0]           sa;
    logic [5:0]           fn;
  } insn_fields_t;

endpackage

// File: rtl/ppc_decode.sv
module ppc_decode
  import ppc_pkg::*;
(
  input  logic [INSN_W-1:0]    instr_i,
  input  logic                 strict_i,
  output copy_op_e             op_o,
  output logic                 valid_o,
  output logic [REG_IDX_W-1:0] rd_o,
  output logic                 wr_en_o,
  output logic                 trap_o
);

  insn_fields_t f;
  logic         in_group;
  logic         unused_ok;

  assign f = insn_fields_t'(instr_i);

  // rs and rt indices are resolved by the operand read, not here
  assign unused_ok = ^{f.rs, f.rt};

  always_comb begin
    op_o     = CP_NONE;
    in_group = (f.opc == OPC_WIDE) &&
               ((f.fn == FN_GRP_HI) || (f.fn == FN_GRP_LO));
    if (f.opc == OPC_WIDE) begin
      if ((f.fn == FN_GRP_HI) && (f.sa == SA_HBCAST)) begin
        op_o = CP_HBC;
      end else if ((f.fn == FN_GRP_HI) && (f.sa == SA_UPACK)) begin
        op_o = CP_UPACK;
      end else if ((f.fn == FN_GRP_LO) && (f.sa == SA_LPACK)) begin
        op_o = CP_LPACK;
      end
    end
    valid_o = (op_o != CP_NONE);
    trap_o  = strict_i && in_group && !valid_o;
    wr_en_o = valid_o && (f.rd != '0);
    rd_o    = valid_o ? f.rd : '0;
  end

endmodule

// File: rtl/ppc_exec.sv
module ppc_exec
  import ppc_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned HALF_W = 16
)(
  input  copy_op_e          op_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int unsigned DW_W  = DATA_W / 2;
  localparam int unsigned LANES = DW_W / HALF_W;

  logic [DATA_W-1:0] bcast;
  logic [DATA_W-1:0] upack;
  logic [DATA_W-1:0] lpack;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bcast[g*HALF_W +: HALF_W]        = rt_i[0 +: HALF_W];
    assign bcast[DW_W + g*HALF_W +: HALF_W] = rt_i[DW_W +: HALF_W];
  end

  assign upack = {rt_i[DW_W +: DW_W], rs_i[DW_W +: DW_W]};
  assign lpack = {rs_i[0 +: DW_W],    rt_i[0 +: DW_W]};

  always_comb begin
    unique case (op_i)
      CP_HBC:   res_o = bcast;
      CP_UPACK: res_o = upack;
      CP_LPACK: res_o = lpack;
      default:  res_o = '0;
    endcase
  end

endmodule

// File: rtl/ppc_copy_unit.sv
module ppc_copy_unit
  import ppc_pkg::*;
#(
  parameter int unsigned DATA_W   = 128,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned MIRROR_W = 32
)(
  input  logic [INSN_W-1:0]    instr_i,
  input  logic [DATA_W-1:0]    rs_val_i,
  input  logic [DATA_W-1:0]    rt_val_i,
  input  logic                 strict_i,
  output logic                 valid_o,
  output logic [REG_IDX_W-1:0] rd_o,
  output logic                 wr_en_o,
  output logic [DATA_W-1:0]    wb128_o,
  output logic [MIRROR_W-1:0]  wb32_o,
  output logic                 trap_o
);

  copy_op_e op;

  ppc_decode u_dec (
    .instr_i  (instr_i),
    .strict_i (strict_i),
    .op_o     (op),
    .valid_o  (valid_o),
    .rd_o     (rd_o),
    .wr_en_o  (wr_en_o),
    .trap_o   (trap_o)
  );

  ppc_exec #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W)
  ) u_exe (
    .op_i  (op),
    .rs_i  (rs_val_i),
    .rt_i  (rt_val_i),
    .res_o (wb128_o)
  );

  assign wb32_o = wb128_o[MIRROR_W-1:0];

endmodule

// File: rtl/ppc_copy_unit_chk.sv
module ppc_copy_unit_chk
  import ppc_pkg::*;
#(
  parameter int unsigned DATA_W   = 128,
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned MIRROR_W = 32
)(
  input  logic [INSN_W-1:0]    instr_i,
  input  logic [DATA_W-1:0]    rs_val_i,
  input  logic [DATA_W-1:0]    rt_val_i,
  input  logic                 strict_i,
  input  logic                 valid_o,
  input  logic [REG_IDX_W-1:0] rd_o,
  input  logic                 wr_en_o,
  input  logic [DATA_W-1:0]    wb128_o,
  input  logic [MIRROR_W-1:0]  wb32_o,
  input  logic                 trap_o
);

  localparam int unsigned DW_W = DATA_W / 2;

  logic is_hbc;
  logic unused_ok;

  assign is_hbc = (instr_i[31:26] == OPC_WIDE) &&
                  (instr_i[5:0] == FN_GRP_HI) &&
                  (instr_i[10:6] == SA_HBCAST);
  assign unused_ok = ^rs_val_i;

  always_comb begin
    a_r7_trap_excl: assert (!(trap_o && (valid_o || wr_en_o)))
      else $error("trap raised with valid or write enable");
    a_r9_we_needs_dest: assert (!wr_en_o || (valid_o && (rd_o != '0)))
      else $error("write enable without valid nonzero destination");
    a_r11_mirror_low: assert (!valid_o || (wb32_o == wb128_o[MIRROR_W-1:0]))
      else $error("mirror differs from result low bits");
    a_r8_no_trap_lenient: assert (strict_i || !trap_o)
      else $error("trap raised with strict mode off");
    a_r10_foreign_quiet: assert ((instr_i[31:26] == OPC_WIDE) || !(valid_o || trap_o))
      else $error("foreign opcode produced valid or trap");
    a_r1_hbc_lanes: assert (!(is_hbc && valid_o) ||
                            ((wb128_o[HALF_W-1:0] == rt_val_i[HALF_W-1:0]) &&
                             (wb128_o[DW_W-1:DW_W-HALF_W] == rt_val_i[HALF_W-1:0]) &&
                             (wb128_o[DW_W +: HALF_W] == rt_val_i[DW_W +: HALF_W]) &&
                             (wb128_o[DATA_W-1:DATA_W-HALF_W] == rt_val_i[DW_W +: HALF_W])))
      else $error("broadcast lanes do not match rt source halfwords");
  end

endmodule

bind ppc_copy_unit ppc_copy_unit_chk #(
  .DATA_W   (DATA_W),
  .HALF_W   (HALF_W),
  .MIRROR_W (MIRROR_W)
) chk_i (.*);

// File: tb/ppc_copy_unit_tb_top.sv
module ppc_copy_unit_tb_top;

  logic          clk = 1'b0;
  logic [31:0]   instr;
  logic [127:0]  rs_val;
  logic [127:0]  rt_val;
  logic          strict;
  logic          valid;
  logic [4:0]    rd;
  logic          wr_en;
  logic [127:0]  wb128;
  logic [31:0]   wb32;
  logic          trap;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ppc_copy_unit dut_i (
    .instr_i  (instr),
    .rs_val_i (rs_val),
    .rt_val_i (rt_val),
    .strict_i (strict),
    .valid_o  (valid),
    .rd_o     (rd),
    .wr_en_o  (wr_en),
    .wb128_o  (wb128),
    .wb32_o   (wb32),
    .trap_o   (trap)
  );

  function automatic logic [31:0] enc(input logic [4:0] rsf, input logic [4:0] rtf,
                                      input logic [4:0] rdf, input logic [4:0] saf,
                                      input logic [5:0] fnf);
    return {6'h1C, rsf, rtf, rdf, saf, fnf};
  endfunction

  function automatic logic [127:0] ref_hbc(input logic [127:0] t);
    return {{4{t[79:64]}}, {4{t[15:0]}}};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [127:0] a,
                       input logic [127:0] b, input logic s);
    @(posedge clk);
    instr  = w;
    rs_val = a;
    rt_val = b;
    strict = s;
    @(negedge clk);
  endtask

  // R10: all-zero word is an idle starting state
  task automatic t_idle();
    apply(32'h0, '0, '0, 1'b1);
    check("R10 idle valid", valid, 0);
    check("R10 idle trap", trap, 0);
    check("R10 idle we", wr_en, 0);
    apply(enc(5'd1, 5'd2, 5'd3, 5'h1B, 6'h28), 128'h1, 128'h2, 1'b1);
    check("R10 other funct valid", valid, 0);
    check("R10 other funct trap", trap, 0);
    apply({6'h00, 5'd0, 5'd8, 5'd3, 5'h1B, 6'h29}, 128'h1, 128'h2, 1'b1);
    check("R10 other opcode valid/trap", {valid, trap, wr_en}, 0);
  endtask

  // R6 R1 R2: the fixed example word
  task automatic t_example();
    logic [127:0] t;
    t = 128'h5555_6666_7777_ABCD_9999_8888_4444_1234;
    apply(32'h70081EE9, 128'hDEAD, t, 1'b1);
    check("R6 valid", valid, 1);
    check("R6 rd", rd, 3);
    check("R6 we", wr_en, 1);
    check("R1 example result", wb128, 128'hABCD_ABCD_ABCD_ABCD_1234_1234_1234_1234);
    check("R2 example mirror", wb32, 32'h1234_1234);
    check("R7 example no trap", trap, 0);
  endtask

  // R1 R2 R11 across several rt patterns
  task automatic t_hbc_patterns();
    for (int i = 0; i < 4; i++) begin
      logic [127:0] t;
      t = {4{32'h1357_9BDF ^ (32'h0F0F_1111 * (i + 1))}} ^ (128'hF00D << (i * 16));
      apply(enc(5'd4, 5'd5, 5'd6, 5'h1B, 6'h29), 128'h0, t, 1'b0);
      check("R1 pattern result", wb128, ref_hbc(t));
      check("R2 pattern mirror", wb32, {t[15:0], t[15:0]});
      check("R11 hbc rd", rd, 6);
    end
  endtask

  // R3: rs field and rs operand have no effect
  task automatic t_rs_ignored();
    logic [127:0] t;
    t = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    for (int i = 0; i < 3; i++) begin
      apply(enc(5'(i * 11 + 3), 5'd8, 5'd11, 5'h1B, 6'h29),
            {4{32'hA5A5_0000 + 32'(i * 7919)}}, t, 1'b1);
      check("R3 result with varied rs", wb128, ref_hbc(t));
      check("R3 mirror with varied rs", wb32, {t[15:0], t[15:0]});
    end
  endtask

  // R4 R5 R11: pack copies
  task automatic t_packs();
    logic [127:0] a, b;
    a = 128'hAAAA_0001_AAAA_0002_AAAA_0003_AAAA_0004;
    b = 128'hBBBB_0001_BBBB_0002_BBBB_0003_BBBB_0004;
    apply(enc(5'd1, 5'd2, 5'd9, 5'h0E, 6'h09), a, b, 1'b1);
    check("R4 lower pack", wb128, {a[63:0], b[63:0]});
    check("R11 lower mirror", wb32, b[31:0]);
    check("R11 lower rd/valid", {valid, rd}, {1'b1, 5'd9});
    apply(enc(5'd1, 5'd2, 5'd31, 5'h0E, 6'h29), a, b, 1'b1);
    check("R5 upper pack", wb128, {b[127:64], a[127:64]});
    check("R11 upper mirror", wb32, a[95:64]);
    check("R11 upper rd/we", {wr_en, rd}, {1'b1, 5'd31});
  endtask

  // R7 R8: neighbouring sa values under strict on and off
  task automatic t_neighbours();
    logic [4:0] sas [4];
    logic [5:0] fns [4];
    sas = '{5'h1C, 5'h1A, 5'h0F, 5'h0D};
    fns = '{6'h29, 6'h29, 6'h29, 6'h09};
    for (int i = 0; i < 4; i++) begin
      apply(enc(5'd1, 5'd2, 5'd3, sas[i], fns[i]), 128'h77, 128'h99, 1'b1);
      check("R7 strict trap", trap, 1);
      check("R7 strict no valid/we", {valid, wr_en}, 0);
      apply(enc(5'd1, 5'd2, 5'd3, sas[i], fns[i]), 128'h77, 128'h99, 1'b0);
      check("R8 lenient flags", {trap, valid, wr_en}, 0);
      check("R8 lenient result", wb128, 0);
    end
  endtask

  // R9: destination zero
  task automatic t_rd_zero();
    apply(enc(5'd0, 5'd8, 5'd0, 5'h1B, 6'h29), 128'h0, 128'h1111_0000_0000_2222, 1'b1);
    check("R9 valid kept", valid, 1);
    check("R9 we dropped", wr_en, 0);
    check("R9 no trap", trap, 0);
    apply(enc(5'd2, 5'd3, 5'd0, 5'h0E, 6'h09), 128'h5, 128'h6, 1'b0);
    check("R9 pack valid/we", {valid, wr_en}, 2'b10);
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instr  = '0;
    rs_val = '0;
    rt_val = '0;
    strict = 1'b0;
    t_idle();
    t_example();
    t_hbc_patterns();
    t_rs_ignored();
    t_packs();
    t_neighbours();
    t_rd_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule